// File: doc/BRIEF.md
# Full-Duplex PCM Serial Port

This block moves 16-bit audio samples between a register-mapped host side and a serial PCM line. A transmit FIFO is filled by host writes and drained one sample per frame onto `serOut`. A receive FIFO is filled from `serIn` one sample per frame and emptied by host reads. Both FIFOs are 32 entries deep. An external clock generator supplies the bit timing as a one-cycle strobe per bit slot (`bitStrobe`) and marks frame starts with `syncIn`. On each strobe the port samples `syncIn` and `serIn` for the slot that is beginning, and it updates `serOut` for that slot. Samples travel MSB first.

Each direction has its own enable and its own framing option. The first data bit either shares the slot of the sync pulse or follows it one slot later. Each FIFO compares its fill count against a 6-bit threshold to raise a DMA request. The status word reports the fill counts, the level flags and four sticky error flags: TX starvation, TX overrun, RX starvation and RX overrun. A host reads the status word and clears the error flags by writing ones to them.

Top module: `pcm_duplex_port`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x0000300C, and `serOut`, `txDmaReq` and `rxDmaReq` are low.
- R2: Control bit 4 sets the TX framing. When the bit is 0, the TX MSB is driven in the slot that carries sync. When the bit is 1, the TX MSB is driven one slot after sync and `serOut` is 0 during the sync slot. Fifteen more bits follow MSB first, and then the line returns to 0.
- R3: Control bit 3 sets the RX framing in the same way. A completed sample enters the RX FIFO. A read at address 2 returns the oldest sample in bits 15:0 and a 1 in bit 16.
- R4: When a TX frame starts with the TX FIFO empty, all 16 bits go out as 0 and sticky status bit 22 is set. Writing a 1 to status bit 22 (address 3) clears the flag.
- R5: A TX write (address 1) while the TX FIFO holds 32 samples is dropped. The write sets sticky status bit 23, and the queued samples are kept.
- R6: A received sample that completes while the RX FIFO holds 32 samples is dropped. It sets sticky status bit 21, and the queued samples are kept in order.
- R7: A read at address 2 with the RX FIFO empty returns 0, with bit 16 clear, and sets sticky status bit 20.
- R8: The status word carries the TX count in bits 19:14 and the RX count in bits 9:4. The TX flags are empty at bit 13, almost-empty (count at most 1) at bit 12, full (32) at bit 11 and almost-full (count at least 31) at bit 10. The RX flags use bits 3, 2, 1 and 0 in the same order.
- R9: `txDmaReq` is high exactly when control bit 6 is set and the TX count is at or below the threshold in control bits 18:13.
- R10: `rxDmaReq` is high exactly when control bit 5 is set and the RX count is at or above the threshold in control bits 12:7.
- R11: A direction is active only when control bit 0 and that direction's FIFO enable are both set. The RX FIFO enable is bit 1 and the TX FIFO enable is bit 2. An inactive direction holds its FIFO empty and ignores writes and serial traffic, and an inactive TX side drives `serOut` to 0. One direction works normally while the other is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 control, 1 TX data, 2 RX data, 3 status |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered, valid the cycle after `rdEn` |
| bitStrobe | input | 1 | One-cycle pulse at the start of each bit slot |
| syncIn | input | 1 | Frame sync, sampled on `bitStrobe` |
| serIn | input | 1 | Serial receive data, sampled on `bitStrobe` |
| serOut | output | 1 | Serial transmit data, updated on `bitStrobe` |
| txDmaReq | output | 1 | TX FIFO needs filling |
| rxDmaReq | output | 1 | RX FIFO needs draining |

## Verification
The port registers every result. A register write or a FIFO push changes the counts, flags and DMA requests one clock after the write strobe is taken. `rdData` holds a read value one clock after `rdEn`. `serOut` carries a new bit, and a completed RX sample reaches the FIFO, one clock after the bit strobe that causes it. The bench drives every strobe for exactly one clock, starting at a falling edge, and samples at the next falling edge, half a period after the rising edge that moves the result. No check therefore races the edge.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  localparam int SAMPLE_W = 16;
  localparam int REG_W    = 32;
  localparam int THR_W    = 6;

  typedef enum logic [1:0] {
    RegCtrl   = 2'd0,
    RegTxData = 2'd1,
    RegRxData = 2'd2,
    RegStatus = 2'd3
  } regSel_t;

  typedef struct packed {
    logic [12:0]      spare;
    logic [THR_W-1:0] txThr;
    logic [THR_W-1:0] rxThr;
    logic             txDmaOn;
    logic             rxDmaOn;
    logic             txLate;
    logic             rxLate;
    logic             txFifoOn;
    logic             rxFifoOn;
    logic             portOn;
  } ctrlWord_t;

  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic txPush;
    logic txOverrun;
    logic txLoad;
    logic txStarve;
    logic txShift;
    logic txIdle;
    logic rxShift;
    logic rxPush;
    logic rxOverrun;
    logic rxPop;
    logic rxStarve;
    logic ctrlWrite;
    logic statWrite;
  } portStrobes_t;

endpackage

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (push && !flush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = store[rdPtr];

endmodule

// File: rtl/pcm_port_ctrl.sv
module pcm_port_ctrl
  import pcm_port_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic [1:0]   addr,
  input  logic         bitStrobe,
  input  logic         syncIn,
  input  logic         txActive,
  input  logic         rxActive,
  input  logic         txLate,
  input  logic         rxLate,
  input  logic         txEmpty,
  input  logic         txFull,
  input  logic         rxEmpty,
  input  logic         rxFull,
  output portStrobes_t strobes
);

  localparam int LANES = 2;          // lane 0 transmits, lane 1 receives
  localparam int BIT_W = $clog2(SAMPLE_W);
  localparam logic [BIT_W-1:0] FRAME_REST = BIT_W'(SAMPLE_W - 1);
  localparam logic [BIT_W-1:0] ONE_LEFT   = BIT_W'(1);

  logic [LANES-1:0] laneOn;
  logic [LANES-1:0] laneLate;
  logic [LANES-1:0] laneFirst;
  logic [LANES-1:0] laneNext;
  logic [LANES-1:0] laneLast;

  assign laneOn   = {rxActive, txActive};
  assign laneLate = {rxLate, txLate};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic             armed;
    logic [BIT_W-1:0] bitsLeft;

    assign laneFirst[g] = bitStrobe && laneOn[g] && (syncIn ? !laneLate[g] : armed);
    assign laneNext[g]  = bitStrobe && laneOn[g] && !syncIn && !armed && (bitsLeft != '0);
    assign laneLast[g]  = laneNext[g] && (bitsLeft == ONE_LEFT);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        armed    <= 1'b0;
        bitsLeft <= '0;
      end else if (!laneOn[g]) begin
        armed    <= 1'b0;
        bitsLeft <= '0;
      end else if (bitStrobe) begin
        if (syncIn) begin
          armed    <= laneLate[g];
          bitsLeft <= laneLate[g] ? '0 : FRAME_REST;
        end else if (armed) begin
          armed    <= 1'b0;
          bitsLeft <= FRAME_REST;
        end else if (bitsLeft != '0) begin
          bitsLeft <= bitsLeft - 1'b1;
        end
      end
    end
  end

  logic txWrite;
  logic rxRead;

  assign txWrite = wrEn && (addr == RegTxData) && txActive;
  assign rxRead  = rdEn && (addr == RegRxData);

  always_comb begin
    strobes           = '0;
    strobes.txPush    = txWrite && !txFull;
    strobes.txOverrun = txWrite && txFull;
    strobes.txLoad    = laneFirst[0] && !txEmpty;
    strobes.txStarve  = laneFirst[0] && txEmpty;
    strobes.txShift   = laneNext[0];
    strobes.txIdle    = bitStrobe && !laneFirst[0] && !laneNext[0];
    strobes.rxShift   = laneFirst[1] || laneNext[1];
    strobes.rxPush    = laneLast[1] && !rxFull;
    strobes.rxOverrun = laneLast[1] && rxFull;
    strobes.rxPop     = rxRead && !rxEmpty;
    strobes.rxStarve  = rxRead && rxEmpty;
    strobes.ctrlWrite = wrEn && (addr == RegCtrl);
    strobes.statWrite = wrEn && (addr == RegStatus);
  end

endmodule

// File: rtl/pcm_port_datapath.sv
module pcm_port_datapath
  import pcm_port_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobes_t     strobes,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wrData,
  input  logic             serIn,
  output logic [REG_W-1:0] rdData,
  output logic             serOut,
  output logic             txDmaReq,
  output logic             rxDmaReq,
  output logic             txActive,
  output logic             rxActive,
  output logic             txLate,
  output logic             rxLate,
  output logic             txEmpty,
  output logic             txFull,
  output logic             rxEmpty,
  output logic             rxFull,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount
);

  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HIGH_CNT  = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] LOW_CNT   = CNT_W'(1);

  ctrlWord_t             ctrlWord;
  logic [SAMPLE_W-1:0]   txHead;
  logic [SAMPLE_W-1:0]   rxHead;
  logic [SAMPLE_W-1:0]   txShreg;
  logic [SAMPLE_W-1:0]   rxShreg;
  logic [SAMPLE_W-1:0]   rxWord;
  logic [3:0]            errFlags;   // {txOverrun, txStarve, rxOverrun, rxStarve}
  logic [3:0]            errSet;
  logic [REG_W-1:0]      statusWord;
  logic [THR_W-1:0]      txLevel;
  logic [THR_W-1:0]      rxLevel;

  assign txActive = ctrlWord.portOn && ctrlWord.txFifoOn;
  assign rxActive = ctrlWord.portOn && ctrlWord.rxFifoOn;
  assign txLate   = ctrlWord.txLate;
  assign rxLate   = ctrlWord.rxLate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  ctrlWord <= '0;
    else if (strobes.ctrlWrite) ctrlWord <= ctrlWord_t'(wrData);
  end

  pcm_sample_fifo #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH)) i_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (!txActive),
    .push     (strobes.txPush),
    .pop      (strobes.txLoad),
    .pushData (wrData[SAMPLE_W-1:0]),
    .headData (txHead),
    .count    (txCount)
  );

  assign rxWord = {rxShreg[SAMPLE_W-2:0], serIn};

  pcm_sample_fifo #(.WIDTH(SAMPLE_W), .DEPTH(DEPTH)) i_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (!rxActive),
    .push     (strobes.rxPush),
    .pop      (strobes.rxPop),
    .pushData (rxWord),
    .headData (rxHead),
    .count    (rxCount)
  );

  assign txEmpty = (txCount == '0);
  assign txFull  = (txCount == FULL_CNT);
  assign rxEmpty = (rxCount == '0);
  assign rxFull  = (rxCount == FULL_CNT);

  // Transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serOut  <= 1'b0;
      txShreg <= '0;
    end else if (!txActive) begin
      serOut  <= 1'b0;
      txShreg <= '0;
    end else if (strobes.txLoad) begin
      serOut  <= txHead[SAMPLE_W-1];
      txShreg <= {txHead[SAMPLE_W-2:0], 1'b0};
    end else if (strobes.txStarve) begin
      serOut  <= 1'b0;
      txShreg <= '0;
    end else if (strobes.txShift) begin
      serOut  <= txShreg[SAMPLE_W-1];
      txShreg <= {txShreg[SAMPLE_W-2:0], 1'b0};
    end else if (strobes.txIdle) begin
      serOut  <= 1'b0;
    end
  end

  // Receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rxShreg <= '0;
    else if (strobes.rxShift) rxShreg <= rxWord;
  end

  // Sticky error flags, set wins over a same-cycle clear
  assign errSet = {strobes.txOverrun, strobes.txStarve, strobes.rxOverrun, strobes.rxStarve};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlags <= '0;
    else       errFlags <= (errFlags & ~(strobes.statWrite ? wrData[23:20] : 4'b0)) | errSet;
  end

  assign txLevel = THR_W'(txCount);
  assign rxLevel = THR_W'(rxCount);

  always_comb begin
    statusWord        = '0;
    statusWord[23:20] = errFlags;
    statusWord[19:14] = txLevel;
    statusWord[13]    = txEmpty;
    statusWord[12]    = (txCount <= LOW_CNT);
    statusWord[11]    = txFull;
    statusWord[10]    = (txCount >= HIGH_CNT);
    statusWord[9:4]   = rxLevel;
    statusWord[3]     = rxEmpty;
    statusWord[2]     = (rxCount <= LOW_CNT);
    statusWord[1]     = rxFull;
    statusWord[0]     = (rxCount >= HIGH_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      case (addr)
        RegCtrl:   rdData <= ctrlWord;
        RegTxData: rdData <= '0;
        RegRxData: rdData <= rxEmpty ? '0 : {{(REG_W-SAMPLE_W-1){1'b0}}, 1'b1, rxHead};
        default:   rdData <= statusWord;
      endcase
    end
  end

  assign txDmaReq = ctrlWord.txDmaOn && (txLevel <= ctrlWord.txThr);
  assign rxDmaReq = ctrlWord.rxDmaOn && (rxLevel >= ctrlWord.rxThr);

endmodule

// File: rtl/pcm_duplex_port.sv
module pcm_duplex_port
  import pcm_port_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        bitStrobe,
  input  logic        syncIn,
  input  logic        serIn,
  output logic        serOut,
  output logic        txDmaReq,
  output logic        rxDmaReq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  portStrobes_t     strobes;
  logic             txActive;
  logic             rxActive;
  logic             txLate;
  logic             rxLate;
  logic             txEmpty;
  logic             txFull;
  logic             rxEmpty;
  logic             rxFull;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;

  pcm_port_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .bitStrobe (bitStrobe),
    .syncIn    (syncIn),
    .txActive  (txActive),
    .rxActive  (rxActive),
    .txLate    (txLate),
    .rxLate    (rxLate),
    .txEmpty   (txEmpty),
    .txFull    (txFull),
    .rxEmpty   (rxEmpty),
    .rxFull    (rxFull),
    .strobes   (strobes)
  );

  pcm_port_datapath #(.DEPTH(DEPTH)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdEn     (rdEn),
    .addr     (addr),
    .wrData   (wrData),
    .serIn    (serIn),
    .rdData   (rdData),
    .serOut   (serOut),
    .txDmaReq (txDmaReq),
    .rxDmaReq (rxDmaReq),
    .txActive (txActive),
    .rxActive (rxActive),
    .txLate   (txLate),
    .rxLate   (rxLate),
    .txEmpty  (txEmpty),
    .txFull   (txFull),
    .rxEmpty  (rxEmpty),
    .rxFull   (rxFull),
    .txCount  (txCount),
    .rxCount  (rxCount)
  );

endmodule

// File: rtl/pcm_duplex_port_chk.sv
module pcm_duplex_port_chk #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [1:0]       addr,
  input logic [16:0]      rdLow,
  input logic             serOut,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic             txActive,
  input logic             rxActive,
  input logic             txLoadStb,
  input logic             txStarveStb
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= FULL_CNT) && (rxCount <= FULL_CNT));

  p_starve_line_r4: assert property (@(posedge clk) disable iff (!rstN)
    txStarveStb |=> !serOut);

  p_tx_full_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == FULL_CNT && txActive && !txLoadStb && !(wrEn && addr == 2'd0))
      |=> (txCount == FULL_CNT));

  p_rx_full_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == FULL_CNT && rxActive && !(rdEn && addr == 2'd2) && !(wrEn && addr == 2'd0))
      |=> (rxCount == FULL_CNT));

  p_rd_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd2 && rxCount == '0) |=> (rdLow == 17'd0));

  p_rd_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 2'd2 && rxCount != '0) |=> rdLow[16]);

  p_idle_line_r11: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |=> !serOut);

  p_inactive_flush_r11: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |=> (txCount == '0));

endmodule

bind pcm_duplex_port pcm_duplex_port_chk #(.DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .rdEn        (rdEn),
  .addr        (addr),
  .rdLow       (rdData[16:0]),
  .serOut      (serOut),
  .txCount     (txCount),
  .rxCount     (rxCount),
  .txActive    (txActive),
  .rxActive    (rxActive),
  .txLoadStb   (strobes.txLoad),
  .txStarveStb (strobes.txStarve)
);

// File: tb/test_pcm_duplex_port.sv
module test_pcm_duplex_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        bitStrobe = 1'b0;
  logic        syncIn = 1'b0;
  logic        serIn = 1'b0;
  logic        serOut;
  logic        txDmaReq;
  logic        rxDmaReq;

  int vecCount = 0;
  int missCount = 0;

  always #5 clk = ~clk;

  pcm_duplex_port i_pcm_duplex_port (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .wrData    (wrData),
    .rdData    (rdData),
    .bitStrobe (bitStrobe),
    .syncIn    (syncIn),
    .serIn     (serIn),
    .serOut    (serOut),
    .txDmaReq  (txDmaReq),
    .rxDmaReq  (rxDmaReq)
  );

  task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic bitTick(logic din, logic sync);
    @(negedge clk);
    bitStrobe = 1'b1; serIn = din; syncIn = sync;
    @(negedge clk);
    bitStrobe = 1'b0; syncIn = 1'b0;
  endtask

  // One frame: drives rxWord on serIn, collects the transmitted word
  task automatic runFrame(bit late, logic [15:0] rxWord, output logic [15:0] txWord,
                          input string tag);
    txWord = '0;
    if (late) begin
      bitTick(1'b1, 1'b1);
      expect32({tag, " sync slot idle"}, {31'b0, serOut}, 32'd0);
      for (int i = 15; i >= 0; i--) begin
        bitTick(rxWord[i], 1'b0);
        txWord[i] = serOut;
      end
    end else begin
      bitTick(rxWord[15], 1'b1);
      txWord[15] = serOut;
      for (int i = 14; i >= 0; i--) begin
        bitTick(rxWord[i], 1'b0);
        txWord[i] = serOut;
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    regRead(2'd0, d);  expect32("R1 control", d, 32'h0);
    regRead(2'd3, d);  expect32("R1 status", d, 32'h0000300C);
    expect32("R1 outputs", {29'b0, serOut, txDmaReq, rxDmaReq}, 32'd0);
  endtask

  task automatic t_tx_framing();
    logic [15:0] w;
    logic [31:0] d;
    regWrite(2'd0, 32'h5);
    regWrite(2'd1, 32'hA5C3);
    runFrame(1'b0, 16'h0, w, "R2 early");
    expect32("R2 early word", {16'b0, w}, 32'hA5C3);
    bitTick(1'b0, 1'b0);
    expect32("R2 idle after frame", {31'b0, serOut}, 32'd0);
    regWrite(2'd0, 32'h15);
    regWrite(2'd1, 32'h3C5A);
    runFrame(1'b1, 16'h0, w, "R2 late");
    expect32("R2 late word", {16'b0, w}, 32'h3C5A);
    regRead(2'd3, d);
    expect32("R2 status after frames", d, 32'h0000300C);
  endtask

  task automatic t_tx_starve();
    logic [15:0] w;
    logic [31:0] d;
    regWrite(2'd0, 32'h5);
    runFrame(1'b0, 16'h0, w, "R4");
    expect32("R4 zeros", {16'b0, w}, 32'd0);
    regRead(2'd3, d);  expect32("R4 flag set", d, 32'h0040300C);
    regWrite(2'd3, 32'h00400000);
    regRead(2'd3, d);  expect32("R4 flag cleared", d, 32'h0000300C);
  endtask

  task automatic t_tx_full();
    logic [15:0] w;
    logic [31:0] d;
    regWrite(2'd0, 32'h5);
    regWrite(2'd1, 32'h1000);
    regRead(2'd3, d);  expect32("R8 one entry", d, 32'h0000500C);
    for (int i = 1; i < 31; i++) regWrite(2'd1, 32'h1000 + i);
    regRead(2'd3, d);  expect32("R8 31 entries", d, 32'h0007C40C);
    regWrite(2'd1, 32'h101F);
    regRead(2'd3, d);  expect32("R8 full", d, 32'h00080C0C);
    regWrite(2'd1, 32'hDEAD);
    regRead(2'd3, d);  expect32("R5 overrun flag", d, 32'h00880C0C);
    runFrame(1'b0, 16'h0, w, "R5");
    expect32("R5 oldest kept", {16'b0, w}, 32'h1000);
    regRead(2'd3, d);  expect32("R5 count after drain", d, 32'h0087C40C);
    regWrite(2'd0, 32'h0);
    regWrite(2'd3, 32'h00F00000);
    regRead(2'd3, d);  expect32("R11 flush on disable", d, 32'h0000300C);
  endtask

  task automatic t_tx_dma();
    logic [15:0] w;
    regWrite(2'd0, 32'h8045);
    expect32("R9 empty requests", {31'b0, txDmaReq}, 32'd1);
    for (int i = 0; i < 4; i++) regWrite(2'd1, 32'h7700 + i);
    expect32("R9 at threshold", {31'b0, txDmaReq}, 32'd1);
    regWrite(2'd1, 32'h7704);
    expect32("R9 above threshold", {31'b0, txDmaReq}, 32'd0);
    runFrame(1'b0, 16'h0, w, "R9");
    expect32("R9 after drain", {31'b0, txDmaReq}, 32'd1);
    regWrite(2'd0, 32'h0);
    expect32("R9 disabled", {31'b0, txDmaReq}, 32'd0);
  endtask

  task automatic t_rx_framing();
    logic [15:0] w;
    logic [31:0] d;
    regWrite(2'd0, 32'h3);
    runFrame(1'b0, 16'hBEEF, w, "R3 early");
    regRead(2'd2, d);  expect32("R3 early read", d, 32'h0001BEEF);
    regRead(2'd2, d);  expect32("R7 empty read", d, 32'h0);
    regRead(2'd3, d);  expect32("R7 flag", d, 32'h0010300C);
    regWrite(2'd3, 32'h00100000);
    regWrite(2'd0, 32'hB);
    runFrame(1'b1, 16'h1234, w, "R3 late");
    regRead(2'd2, d);  expect32("R3 late read", d, 32'h00011234);
    regRead(2'd3, d);  expect32("R3 status", d, 32'h0000300C);
  endtask

  task automatic t_rx_overrun();
    logic [15:0] w;
    logic [31:0] d;
    regWrite(2'd0, 32'h3);
    for (int i = 0; i < 32; i++) runFrame(1'b0, 16'h2000 + 16'(i), w, "R6 fill");
    regRead(2'd3, d);  expect32("R8 rx full", d, 32'h00003203);
    runFrame(1'b0, 16'hFFFF, w, "R6 extra");
    regRead(2'd3, d);  expect32("R6 overrun flag", d, 32'h00203203);
    regRead(2'd2, d);  expect32("R6 oldest kept", d, 32'h00012000);
    regRead(2'd2, d);  expect32("R6 order kept", d, 32'h00012001);
    regWrite(2'd0, 32'h0);
    regWrite(2'd3, 32'h00F00000);
  endtask

  task automatic t_rx_dma();
    logic [15:0] w;
    logic [31:0] d;
    regWrite(2'd0, 32'h123);
    expect32("R10 empty", {31'b0, rxDmaReq}, 32'd0);
    runFrame(1'b0, 16'h0101, w, "R10");
    expect32("R10 below threshold", {31'b0, rxDmaReq}, 32'd0);
    runFrame(1'b0, 16'h0202, w, "R10");
    expect32("R10 at threshold", {31'b0, rxDmaReq}, 32'd1);
    regRead(2'd2, d);
    expect32("R10 drained below", {31'b0, rxDmaReq}, 32'd0);
    regWrite(2'd0, 32'h0);
  endtask

  task automatic t_independent();
    logic [15:0] w;
    logic [31:0] d;
    regWrite(2'd0, 32'h4);
    regWrite(2'd1, 32'hFFFF);
    regRead(2'd3, d);  expect32("R11 port off write ignored", d, 32'h0000300C);
    bitTick(1'b1, 1'b1);
    expect32("R11 port off line", {31'b0, serOut}, 32'd0);
    regWrite(2'd0, 32'h7);
    regWrite(2'd1, 32'h0F0F);
    runFrame(1'b0, 16'h5A5A, w, "R11 duplex");
    expect32("R11 duplex tx", {16'b0, w}, 32'h0F0F);
    regRead(2'd2, d);  expect32("R11 duplex rx", d, 32'h00015A5A);
    regWrite(2'd0, 32'h5);
    regWrite(2'd1, 32'h00FF);
    runFrame(1'b0, 16'hAAAA, w, "R11 tx only");
    expect32("R11 tx only word", {16'b0, w}, 32'h00FF);
    regRead(2'd3, d);  expect32("R11 rx off stays empty", d, 32'h0000300C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_tx_framing();
    t_tx_starve();
    t_tx_full();
    t_tx_dma();
    t_rx_framing();
    t_rx_overrun();
    t_rx_dma();
    t_independent();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule